// File: doc/BRIEF.md
# Configuration control word loader

This block captures the 32-bit control word that opens every configuration download. The word arrives either one bit per strobe (serial) or one byte per strobe (parallel). The mode is sampled when a download starts. While the word is being gathered it builds up in a private shift buffer. The visible control word changes in one step, at the edge that accepts the final beat. Three control bits are decoded from it: address-counter retain, cascade-output disable and check-function disable.

The block also holds a 24-bit external-memory address up-counter. The counter steps on its own increment strobe. When a download is reported as finished, the retain bit decides what happens to it: a clear retain bit sends it back to zero, and a set retain bit leaves its value in place, so that designs stored back to back in memory can be fetched in turn. A configuration clear cycle zeroes the control word, the load state and the counter.

Top module: `cfg_ctrl_loader`

## Requirements
- R1: Reset, or a `clear_i` pulse (which wins over every other input), sets `ctrl_word_o`, `load_done_o`, the three decoded outputs and `addr_o` to 0 on the next edge. Beats that arrive after a clear without a new `start_i` are not accepted.
- R2: In serial mode, 32 accepted bits form the word, and the first bit accepted lands in bit 31.
- R3: In parallel mode, 4 accepted bytes form the word. The first byte accepted fills bits 31..24, the second 23..16, the third 15..8 and the fourth 7..0.
- R4: `par_mode_i` is sampled on the `start_i` edge (1 = parallel, 0 = serial). Changing it later in the download has no effect.
- R5: A beat is accepted only when `load_vld_i` is 1, and idle cycles between beats change nothing. `ctrl_word_o` keeps its previous value until the final beat. `load_done_o` rises, together with the new word, on the edge that accepts beat 32 (serial) or beat 4 (parallel).
- R6: After `load_done_o` is set, further strobes change neither the word nor the done flag until the next `start_i`.
- R7: `retain_o` is bit 0, `casc_dis_o` is bit 2 and `chk_dis_o` is bit 3 of the committed word. Bit 1 affects no output other than `ctrl_word_o`.
- R8: A `dl_end_i` pulse sets `addr_o` to 0 when `retain_o` is 0, and leaves it unchanged when `retain_o` is 1.
- R9: An `addr_inc_i` pulse adds one to `addr_o`. When it arrives in the same cycle as `dl_end_i`, the reset wins if `retain_o` is 0, and the increment applies if `retain_o` is 1.
- R10: `start_i` during a partial load throws away the beats gathered so far and restarts the count.
- R11: A strobe in the same cycle as `start_i` is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Configuration clear cycle; zeroes all state |
| start_i | input | 1 | Begins a download and samples the mode |
| par_mode_i | input | 1 | 1 = parallel bytes, 0 = serial bits |
| load_vld_i | input | 1 | Qualifies one beat |
| ser_bit_i | input | 1 | Serial data bit |
| par_byte_i | input | 8 | Parallel data byte |
| dl_end_i | input | 1 | Download completed pulse |
| addr_inc_i | input | 1 | Address counter increment |
| load_done_o | output | 1 | Full word captured |
| ctrl_word_o | output | 32 | Committed control word |
| retain_o | output | 1 | Address-counter retain (bit 0) |
| casc_dis_o | output | 1 | Cascade output disable (bit 2) |
| chk_dis_o | output | 1 | Check function disable (bit 3) |
| addr_o | output | 24 | External memory address counter |

## Verification
Serial and parallel loads use words with unequal bytes and bits. A reversed bit order, a reversed byte order or an off-by-one beat count therefore each give a different result. Some loads put idle cycles with toggling data between beats, some send extra strobes after completion, some restart mid-load, some place a strobe in the same cycle as start, and some flip the mode input partway through. Together these show whether beats are qualified properly, whether completion is final, and whether the mode is latched at start. The address counter is stepped and then ended with each retain value, with and without a coincident increment, which separates the reset-wins case from the increment-wins case.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;
  localparam int WORD_W     = 32;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 24;
  localparam int RETAIN_IDX = 0;
  localparam int CASC_IDX   = 2;
  localparam int CHK_IDX    = 3;

  typedef enum logic {
    MODE_SER = 1'b0,
    MODE_PAR = 1'b1
  } ldr_mode_e;
endpackage

// File: rtl/cfg_word_assembler.sv
module cfg_word_assembler
  import cfg_ldr_pkg::*;
#(
  parameter int WORD_W = cfg_ldr_pkg::WORD_W,
  parameter int BYTE_W = cfg_ldr_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              start_i,
  input  logic              par_mode_i,
  input  logic              vld_i,
  input  logic              ser_bit_i,
  input  logic [BYTE_W-1:0] par_byte_i,
  output logic              accept_o,
  output logic              complete_o,
  output logic [WORD_W-1:0] word_next_o,
  output logic              done_o
);
  localparam int SER_BEATS = WORD_W;
  localparam int PAR_BEATS = WORD_W / BYTE_W;
  localparam int CNT_W     = $clog2(WORD_W + 1);

  function automatic logic [WORD_W-1:0] push_bit(input logic [WORD_W-1:0] w,
                                                 input logic b);
    return {w[WORD_W-2:0], b};
  endfunction

  function automatic logic [WORD_W-1:0] push_byte(input logic [WORD_W-1:0] w,
                                                  input logic [BYTE_W-1:0] b);
    return {w[WORD_W-BYTE_W-1:0], b};
  endfunction

  logic [WORD_W-1:0] buf_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  beats_need;
  logic              armed_q;
  logic              done_q;
  ldr_mode_e         mode_q;

  always_comb begin
    accept_o    = vld_i & armed_q & ~start_i & ~clear_i;
    word_next_o = (mode_q == MODE_PAR) ? push_byte(buf_q, par_byte_i)
                                       : push_bit(buf_q, ser_bit_i);
    beats_need  = (mode_q == MODE_PAR) ? CNT_W'(PAR_BEATS) : CNT_W'(SER_BEATS);
    complete_o  = accept_o && (cnt_q == beats_need - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      mode_q  <= MODE_SER;
    end else if (clear_i) begin
      buf_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      mode_q  <= MODE_SER;
    end else if (start_i) begin
      buf_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b1;
      done_q  <= 1'b0;
      mode_q  <= ldr_mode_e'(par_mode_i);
    end else if (accept_o) begin
      buf_q <= word_next_o;
      cnt_q <= cnt_q + 1'b1;
      if (complete_o) begin
        armed_q <= 1'b0;
        done_q  <= 1'b1;
      end
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/cfg_word_commit.sv
module cfg_word_commit
  import cfg_ldr_pkg::*;
#(
  parameter int WORD_W     = cfg_ldr_pkg::WORD_W,
  parameter int RETAIN_IDX = cfg_ldr_pkg::RETAIN_IDX,
  parameter int CASC_IDX   = cfg_ldr_pkg::CASC_IDX,
  parameter int CHK_IDX    = cfg_ldr_pkg::CHK_IDX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              complete_i,
  input  logic [WORD_W-1:0] word_next_i,
  output logic [WORD_W-1:0] word_o,
  output logic              retain_o,
  output logic              casc_dis_o,
  output logic              chk_dis_o
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          word_q <= '0;
    else if (clear_i)    word_q <= '0;
    else if (complete_i) word_q <= word_next_i;
  end

  assign word_o     = word_q;
  assign retain_o   = word_q[RETAIN_IDX];
  assign casc_dis_o = word_q[CASC_IDX];
  assign chk_dis_o  = word_q[CHK_IDX];
endmodule

// File: rtl/cfg_addr_counter.sv
module cfg_addr_counter #(
  parameter int ADDR_W = cfg_ldr_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              dl_end_i,
  input  logic              retain_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  logic [ADDR_W-1:0] addr_q;
  logic              end_reset;

  assign end_reset = dl_end_i & ~retain_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr_q <= '0;
    else if (clear_i)   addr_q <= '0;
    else if (end_reset) addr_q <= '0;
    else if (inc_i)     addr_q <= addr_step(addr_q);
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/cfg_ctrl_loader.sv
module cfg_ctrl_loader
  import cfg_ldr_pkg::*;
#(
  parameter int WORD_W = cfg_ldr_pkg::WORD_W,
  parameter int BYTE_W = cfg_ldr_pkg::BYTE_W,
  parameter int ADDR_W = cfg_ldr_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              start_i,
  input  logic              par_mode_i,
  input  logic              load_vld_i,
  input  logic              ser_bit_i,
  input  logic [BYTE_W-1:0] par_byte_i,
  input  logic              dl_end_i,
  input  logic              addr_inc_i,
  output logic              load_done_o,
  output logic [WORD_W-1:0] ctrl_word_o,
  output logic              retain_o,
  output logic              casc_dis_o,
  output logic              chk_dis_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              accept_w;
  logic              complete_w;
  logic [WORD_W-1:0] word_next_w;

  cfg_word_assembler #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear_i),
    .start_i    (start_i),
    .par_mode_i (par_mode_i),
    .vld_i      (load_vld_i),
    .ser_bit_i  (ser_bit_i),
    .par_byte_i (par_byte_i),
    .accept_o   (accept_w),
    .complete_o (complete_w),
    .word_next_o(word_next_w),
    .done_o     (load_done_o)
  );

  cfg_word_commit #(.WORD_W(WORD_W)) u_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear_i),
    .complete_i (complete_w),
    .word_next_i(word_next_w),
    .word_o     (ctrl_word_o),
    .retain_o   (retain_o),
    .casc_dis_o (casc_dis_o),
    .chk_dis_o  (chk_dis_o)
  );

  cfg_addr_counter #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (clear_i),
    .dl_end_i(dl_end_i),
    .retain_i(retain_o),
    .inc_i   (addr_inc_i),
    .addr_o  (addr_o)
  );
endmodule

// File: rtl/cfg_ctrl_loader_chk.sv
module cfg_ctrl_loader_chk #(
  parameter int WORD_W = cfg_ldr_pkg::WORD_W,
  parameter int ADDR_W = cfg_ldr_pkg::ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear_i,
  input logic              start_i,
  input logic              dl_end_i,
  input logic              addr_inc_i,
  input logic              accept_w,
  input logic              complete_w,
  input logic              load_done_o,
  input logic [WORD_W-1:0] ctrl_word_o,
  input logic              retain_o,
  input logic [ADDR_W-1:0] addr_o
);
  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (ctrl_word_o == '0) && !load_done_o && (addr_o == '0));

  // R5
  word_commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !complete_w) |=> $stable(ctrl_word_o));

  // R5
  complete_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (complete_w && !clear_i) |=> load_done_o);

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done_o && !start_i && !clear_i) |=> load_done_o && $stable(ctrl_word_o));

  // R11
  start_blocks_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !accept_w);

  // R8
  addr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_end_i && !retain_o) |=> (addr_o == '0));

  // R8
  addr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_end_i && retain_o && !addr_inc_i && !clear_i) |=> $stable(addr_o));

  // R9
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_inc_i && !clear_i && !(dl_end_i && !retain_o))
      |=> (addr_o == ADDR_W'($past(addr_o) + 1'b1)));
endmodule

bind cfg_ctrl_loader cfg_ctrl_loader_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear_i    (clear_i),
  .start_i    (start_i),
  .dl_end_i   (dl_end_i),
  .addr_inc_i (addr_inc_i),
  .accept_w   (accept_w),
  .complete_w (complete_w),
  .load_done_o(load_done_o),
  .ctrl_word_o(ctrl_word_o),
  .retain_o   (retain_o),
  .addr_o     (addr_o)
);

// File: tb/cfg_ctrl_loader_tb.sv
module cfg_ctrl_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear_i = 1'b0;
  logic        start_i = 1'b0;
  logic        par_mode_i = 1'b0;
  logic        load_vld_i = 1'b0;
  logic        ser_bit_i = 1'b0;
  logic [7:0]  par_byte_i = 8'h00;
  logic        dl_end_i = 1'b0;
  logic        addr_inc_i = 1'b0;
  logic        load_done_o;
  logic [31:0] ctrl_word_o;
  logic        retain_o;
  logic        casc_dis_o;
  logic        chk_dis_o;
  logic [23:0] addr_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cfg_ctrl_loader u_dut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .start_i(start_i),
    .par_mode_i(par_mode_i), .load_vld_i(load_vld_i), .ser_bit_i(ser_bit_i),
    .par_byte_i(par_byte_i), .dl_end_i(dl_end_i), .addr_inc_i(addr_inc_i),
    .load_done_o(load_done_o), .ctrl_word_o(ctrl_word_o), .retain_o(retain_o),
    .casc_dis_o(casc_dis_o), .chk_dis_o(chk_dis_o), .addr_o(addr_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_start(input logic pm);
    start_i = 1'b1; par_mode_i = pm; cyc(); start_i = 1'b0;
  endtask

  task automatic ser_beat(input logic b);
    load_vld_i = 1'b1; ser_bit_i = b; cyc(); load_vld_i = 1'b0;
  endtask

  task automatic par_beat(input logic [7:0] b);
    load_vld_i = 1'b1; par_byte_i = b; cyc(); load_vld_i = 1'b0;
  endtask

  task automatic load_par(input logic [31:0] w);
    do_start(1'b1);
    for (int i = 3; i >= 0; i--) par_beat(w[i*8 +: 8]);
  endtask

  task automatic t_reset();
    check("R1 reset word", ctrl_word_o, 32'h0);
    check("R1 reset done", {31'b0, load_done_o}, 32'h0);
    check("R1 reset decoded", {29'b0, retain_o, casc_dis_o, chk_dis_o}, 32'h0);
    check("R1 reset addr", {8'b0, addr_o}, 32'h0);
  endtask

  task automatic t_serial();
    logic [31:0] w = 32'hA5C3_0F1E;
    logic [31:0] prev = ctrl_word_o;
    do_start(1'b0);
    for (int i = 31; i >= 1; i--) ser_beat(w[i]);
    check("R5 serial not done at 31", {31'b0, load_done_o}, 32'h0);
    check("R5 serial word held at 31", ctrl_word_o, prev);
    ser_beat(w[0]);
    check("R2 serial msb first", ctrl_word_o, w);
    check("R5 serial done at 32", {31'b0, load_done_o}, 32'h1);
    check("R7 decode A5C30F1E", {29'b0, retain_o, casc_dis_o, chk_dis_o}, 32'h3);
  endtask

  task automatic t_parallel();
    logic [31:0] w = 32'h1234_56F9;
    logic [31:0] prev = ctrl_word_o;
    do_start(1'b1);
    for (int i = 3; i >= 1; i--) par_beat(w[i*8 +: 8]);
    check("R5 parallel not done at 3", {31'b0, load_done_o}, 32'h0);
    check("R5 parallel word held at 3", ctrl_word_o, prev);
    par_beat(w[7:0]);
    check("R3 parallel byte order", ctrl_word_o, w);
    check("R5 parallel done at 4", {31'b0, load_done_o}, 32'h1);
    check("R7 decode 123456F9", {29'b0, retain_o, casc_dis_o, chk_dis_o}, 32'h5);
  endtask

  task automatic t_decode();
    load_par(32'h0000_0002);
    check("R7 bit1 no decoded effect", {29'b0, retain_o, casc_dis_o, chk_dis_o}, 32'h0);
    load_par(32'h0000_0005);
    check("R7 decode 00000005", {29'b0, retain_o, casc_dis_o, chk_dis_o}, 32'h6);
    load_par(32'h0000_0008);
    check("R7 decode 00000008", {29'b0, retain_o, casc_dis_o, chk_dis_o}, 32'h1);
  endtask

  task automatic t_gaps();
    logic [31:0] w = 32'h0F0F_F0F1;
    do_start(1'b0);
    for (int i = 31; i >= 0; i--) begin
      ser_beat(w[i]);
      ser_bit_i = ~w[i]; par_byte_i = 8'hAA; cyc();
    end
    check("R5 gaps ignored", ctrl_word_o, w);
  endtask

  task automatic t_after_done();
    logic [31:0] w = ctrl_word_o;
    for (int i = 0; i < 8; i++) ser_beat(~w[31 - i]);
    check("R6 extra beats ignored word", ctrl_word_o, w);
    check("R6 extra beats done held", {31'b0, load_done_o}, 32'h1);
  endtask

  task automatic t_mode();
    logic [31:0] w = 32'hC0DE_4213;
    do_start(1'b1);
    par_mode_i = 1'b0;
    for (int i = 3; i >= 0; i--) begin
      ser_bit_i = 1'b1; par_beat(w[i*8 +: 8]);
    end
    check("R4 parallel latched at start", ctrl_word_o, w);
    check("R4 parallel done at 4", {31'b0, load_done_o}, 32'h1);
    w = 32'h8765_4321;
    do_start(1'b0);
    par_mode_i = 1'b1;
    for (int i = 31; i >= 0; i--) begin
      par_byte_i = 8'hFF; ser_beat(w[i]);
      if (i == 28) check("R4 serial not done early", {31'b0, load_done_o}, 32'h0);
    end
    check("R4 serial latched at start", ctrl_word_o, w);
    par_mode_i = 1'b0;
  endtask

  task automatic t_restart();
    logic [31:0] w = 32'h1357_9BDF;
    do_start(1'b0);
    for (int i = 0; i < 10; i++) ser_beat(1'b1);
    do_start(1'b0);
    for (int i = 31; i >= 0; i--) ser_beat(w[i]);
    check("R10 restart discards partial", ctrl_word_o, w);
  endtask

  task automatic t_priority();
    logic [31:0] w = 32'h2468_ACE0;
    start_i = 1'b1; par_mode_i = 1'b1; load_vld_i = 1'b1; par_byte_i = 8'hFF;
    cyc();
    start_i = 1'b0; load_vld_i = 1'b0;
    for (int i = 3; i >= 1; i--) par_beat(w[i*8 +: 8]);
    check("R11 start beat not counted", {31'b0, load_done_o}, 32'h0);
    par_beat(w[7:0]);
    check("R11 word after start beat", ctrl_word_o, w);
    do_start(1'b0);
    for (int i = 0; i < 5; i++) ser_beat(1'b1);
    addr_inc_i = 1'b1; cyc(); addr_inc_i = 1'b0;
    clear_i = 1'b1; load_vld_i = 1'b1; start_i = 1'b1; addr_inc_i = 1'b1; cyc();
    clear_i = 1'b0; load_vld_i = 1'b0; start_i = 1'b0; addr_inc_i = 1'b0;
    check("R1 clear word", ctrl_word_o, 32'h0);
    check("R1 clear done", {31'b0, load_done_o}, 32'h0);
    check("R1 clear addr", {8'b0, addr_o}, 32'h0);
    for (int i = 0; i < 32; i++) ser_beat(1'b1);
    check("R1 no load after clear word", ctrl_word_o, 32'h0);
    check("R1 no load after clear done", {31'b0, load_done_o}, 32'h0);
  endtask

  task automatic t_addr();
    for (int i = 0; i < 5; i++) begin addr_inc_i = 1'b1; cyc(); end
    addr_inc_i = 1'b0;
    check("R9 increment by one", {8'b0, addr_o}, 32'd5);
    load_par(32'h0000_0000);
    dl_end_i = 1'b1; cyc(); dl_end_i = 1'b0;
    check("R8 end resets addr", {8'b0, addr_o}, 32'd0);
    for (int i = 0; i < 3; i++) begin addr_inc_i = 1'b1; cyc(); end
    addr_inc_i = 1'b0;
    load_par(32'h0000_0001);
    dl_end_i = 1'b1; cyc(); dl_end_i = 1'b0;
    check("R8 end retains addr", {8'b0, addr_o}, 32'd3);
    dl_end_i = 1'b1; addr_inc_i = 1'b1; cyc(); dl_end_i = 1'b0; addr_inc_i = 1'b0;
    check("R9 inc wins with retain", {8'b0, addr_o}, 32'd4);
    load_par(32'h0000_0000);
    dl_end_i = 1'b1; addr_inc_i = 1'b1; cyc(); dl_end_i = 1'b0; addr_inc_i = 1'b0;
    check("R9 reset wins without retain", {8'b0, addr_o}, 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_serial();
    t_parallel();
    t_decode();
    t_gaps();
    t_after_done();
    t_mode();
    t_restart();
    t_priority();
    t_addr();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule